// File: doc/BRIEF.md
# Two-Stage Half-Step Baud Tick Generator

This block produces the bit-rate timing for a serial port. It works in two counter stages. The first stage, the prescaler, divides the system clock by a ratio that can be set in steps of one half. The second stage counts the prescaled ticks and divides them by a whole-number divisor. The prescaled tick and the final baud tick each leave the block as a one-cycle enable pulse in the system clock domain. The same baud tick paces both asynchronous and synchronous framing downstream.

Two registers set the rates: a prescaler code and a divisor. Software loads them through a simple write port. Any write to either register restarts both counters. A half-step ratio comes from alternating a short period and a long period, so the average rate is exact and the spacing between ticks varies by at most one system clock.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst_n` is low, both tick outputs are 0. Reset loads prescaler code 0 and divisor 1. The first cycle after reset release counts as cycle 0 of a fresh period.
- R2: An even prescaler code P gives a prescaled tick every (P+2)/2 system cycles.
- R3: An odd prescaler code P gives periods that alternate between (P+1)/2 and (P+3)/2 cycles, with the short period first. The n-th prescaled tick after a restart falls in cycle floor(n*(P+2)/2)-1.
- R4: With a divisor N of 1 or more, `baud_tick` is high on every N-th prescaled tick, counted from the restart. So the m-th baud tick falls in cycle floor(m*N*(P+2)/2)-1.
- R5: A divisor value of 0 behaves exactly like a divisor of 1.
- R6: A write is accepted at the clock edge where `wr_en` is high. If `wr_sel` is 0, the prescaler code takes the low PRE_W bits of `wr_data`. If `wr_sel` is 1, the divisor takes all of `wr_data`. At that same edge both counters and the half-step phase clear, so the first cycle after the edge is cycle 0 of the new timing.
- R7: `baud_tick` is never high unless `pre_tick` is high in the same cycle. With a divisor above 1, a baud tick is never followed directly by another.
- R8: Prescaler code 0 with divisor 1 gives a tick on both outputs in every cycle, so the clock is never stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = prescaler code, 1 = divisor |
| wr_data | input | DIV_W | Write data |
| pre_tick | output | 1 | One-cycle enable at the prescaled rate |
| baud_tick | output | 1 | One-cycle enable at the final bit rate |

## Verification
Both ticks are Moore outputs of the counter state. After a write edge, cycle 0 of the new timing is therefore the first full cycle after that edge, and the n-th prescaled tick is due in cycle floor(n*(P+2)/2)-1. The bench drives each write on a falling edge and takes its first sample on the next falling edge. From there it samples once per cycle. At every sample it compares both outputs against a tick count that it works out on its own with integer division, (2c+3)/K, where K is (P+2) for the prescaled tick and N*(P+2) for the baud tick. This lets every cycle of a run be checked, both the gaps between ticks and the exact cycle of each tick.

// File: rtl/baudgen_pkg.sv
package baudgen_pkg;

  // Length in system cycles of the current prescaler period.
  // Code P gives the ratio (P+2)/2. An odd code alternates between the
  // short period (phase 0) and the long period (phase 1).
  function automatic int unsigned pre_period(int unsigned code, bit phase);
    int unsigned half;
    half = code >> 1;
    if (code[0] == 1'b0) return half + 1;
    else if (phase)      return half + 2;
    else                 return half + 1;
  endfunction

  // Effective divisor: a divisor of 0 counts as 1.
  function automatic int unsigned eff_div(int unsigned d);
    return (d == 0) ? 1 : d;
  endfunction

endpackage

// File: rtl/baudgen_regs.sv
module baudgen_regs #(
  parameter int PRE_W   = 8,
  parameter int DIV_W   = 16,
  parameter int RST_PRE = 0,
  parameter int RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic [PRE_W-1:0] pre_code,
  output logic [DIV_W-1:0] div_val,
  output logic             restart
);

  localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(RST_PRE);
  localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(RST_DIV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_code <= PRE_INIT;
      div_val  <= DIV_INIT;
    end else if (wr_en) begin
      if (wr_sel) div_val  <= wr_data;
      else        pre_code <= wr_data[PRE_W-1:0];
    end
  end

  // A write to either register restarts both stages at the same edge.
  assign restart = wr_en;

endmodule

// File: rtl/baudgen_prescale.sv
module baudgen_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [PRE_W-1:0] code,
  output logic             tick,
  output logic [PRE_W-1:0] cnt,
  output logic             phase,
  output logic [PRE_W-1:0] period
);

  localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

  assign period = PRE_W'(baudgen_pkg::pre_period(32'(code), phase));
  assign tick   = (cnt == period - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (restart) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      phase <= ~phase;
    end else begin
      cnt   <= cnt + ONE;
    end
  end

endmodule

// File: rtl/baudgen_divider.sv
module baudgen_divider #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             pre_tick,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic [DIV_W-1:0] cnt,
  output logic [DIV_W-1:0] div_eff
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  assign div_eff = DIV_W'(baudgen_pkg::eff_div(32'(div_val)));
  assign tick    = pre_tick && (cnt == div_eff - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (restart)  cnt <= '0;
    else if (tick)     cnt <= '0;
    else if (pre_tick) cnt <= cnt + ONE;
  end

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int PRE_W   = 8,
  parameter int DIV_W   = 16,
  parameter int RST_PRE = 0,
  parameter int RST_DIV = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [DIV_W-1:0] wr_data,
  output logic             pre_tick,
  output logic             baud_tick
);

  // Named internal events, brought out for the checker.
  logic [PRE_W-1:0] pre_code;
  logic [DIV_W-1:0] div_val;
  logic             restart;
  logic             pre_tick_raw;
  logic             baud_tick_raw;
  logic [PRE_W-1:0] pre_cnt;
  logic             pre_phase;
  logic [PRE_W-1:0] pre_period_w;
  logic [DIV_W-1:0] div_cnt;
  logic [DIV_W-1:0] div_eff_w;

  baudgen_regs #(
    .PRE_W(PRE_W), .DIV_W(DIV_W), .RST_PRE(RST_PRE), .RST_DIV(RST_DIV)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pre_code(pre_code), .div_val(div_val),
    .restart(restart)
  );

  baudgen_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(restart), .code(pre_code),
    .tick(pre_tick_raw), .cnt(pre_cnt), .phase(pre_phase),
    .period(pre_period_w)
  );

  baudgen_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(restart), .pre_tick(pre_tick_raw),
    .div_val(div_val), .tick(baud_tick_raw), .cnt(div_cnt),
    .div_eff(div_eff_w)
  );

  assign pre_tick  = pre_tick_raw  & rst_n;
  assign baud_tick = baud_tick_raw & rst_n;

endmodule

// File: rtl/baudgen_chk.sv
module baudgen_chk #(
  parameter int PRE_W = 8,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic             pre_tick,
  input logic             baud_tick,
  input logic [PRE_W-1:0] pre_code,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PRE_W-1:0] pre_period_w,
  input logic [DIV_W-1:0] div_cnt,
  input logic [DIV_W-1:0] div_eff_w
);

  always_comb begin
    if (!rst_n) AST_QUIET_IN_RESET: assert (!pre_tick && !baud_tick); // R1
  end

  AST_PRE_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_cnt < pre_period_w); // R3

  AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (pre_cnt == '0) && (div_cnt == '0)); // R6

  AST_BAUD_NEEDS_PRE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> pre_tick); // R7

  AST_BAUD_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_tick && div_eff_w > 1 && !wr_en) |=> !baud_tick); // R7

  AST_DIV_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt < div_eff_w); // R4

  AST_DIV_ZERO_AS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    div_eff_w != '0); // R5

  AST_EVEN_CODE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_tick && pre_code >= 2 && !wr_en) |=> !pre_tick); // R2

  AST_CODE0_NEVER_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_code == '0) |-> pre_tick); // R8

endmodule

bind baud_tick_gen baudgen_chk #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .pre_tick(pre_tick),
  .baud_tick(baud_tick), .pre_code(pre_code), .pre_cnt(pre_cnt),
  .pre_period_w(pre_period_w), .div_cnt(div_cnt), .div_eff_w(div_eff_w)
);

// File: tb/test_baud_tick_gen.sv
module test_baud_tick_gen;

  localparam int CLK_PERIOD = 10;
  localparam int PRE_W = 8;
  localparam int DIV_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic             wr_sel = 1'b0;
  logic [DIV_W-1:0] wr_data = '0;
  logic             pre_tick;
  logic             baud_tick;

  int n_checks = 0;
  int n_fails  = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen #(.PRE_W(PRE_W), .DIV_W(DIV_W)) i_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .pre_tick(pre_tick), .baud_tick(baud_tick)
  );

  task automatic check(string req, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Expected tick in cycle c when ticks fall at floor(n*K/2)-1.
  function automatic bit tick_due(int c, int k);
    return ((2*c + 3) / k) != ((2*c + 1) / k);
  endfunction

  // State was just zeroed; sample now and then on every falling edge.
  task automatic run(int p, int n, int cycles, string req);
    int neff;
    neff = (n == 0) ? 1 : n;
    for (int c = 0; c < cycles; c++) begin
      check(req, "pre_tick",  pre_tick,  tick_due(c, p + 2));
      check(req, "baud_tick", baud_tick, tick_due(c, neff * (p + 2)));
      @(negedge clk);
    end
  endtask

  task automatic wr(bit sel, int data);
    wr_en   = 1'b1;
    wr_sel  = sel;
    wr_data = DIV_W'(data);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", "pre_tick in reset",  pre_tick,  1'b0);
    check("R1", "baud_tick in reset", baud_tick, 1'b0);
    rst_n = 1'b1;
    #1;
    run(0, 1, 8, "R1");
  endtask

  task automatic t_code0;
    wr(1'b0, 0); wr(1'b1, 1);
    run(0, 1, 10, "R8");
  endtask

  task automatic t_even;
    wr(1'b0, 2); wr(1'b1, 3);
    run(2, 3, 30, "R2");
    wr(1'b1, 1); wr(1'b0, 6);
    run(6, 1, 30, "R2");
  endtask

  task automatic t_odd;
    wr(1'b1, 1); wr(1'b0, 1);
    run(1, 1, 20, "R3");
    wr(1'b0, 5);
    run(5, 1, 40, "R3");
  endtask

  task automatic t_divide;
    wr(1'b0, 3); wr(1'b1, 4);
    run(3, 4, 60, "R4");
    wr(1'b0, 0); wr(1'b1, 5);
    run(0, 5, 25, "R7");
  endtask

  task automatic t_div_zero;
    wr(1'b0, 3); wr(1'b1, 0);
    run(3, 0, 30, "R5");
  endtask

  task automatic t_restart;
    wr(1'b0, 5); wr(1'b1, 2);
    run(5, 2, 11, "R6");
    wr(1'b1, 2);
    run(5, 2, 40, "R6");
    // prescaler field takes only the low PRE_W bits
    wr(1'b0, 32'h0103);
    run(3, 2, 40, "R6");
  endtask

  task automatic t_large;
    wr(1'b0, 255); wr(1'b1, 2);
    run(255, 2, 600, "R3");
  endtask

  initial begin
    t_reset();
    t_code0();
    t_even();
    t_odd();
    t_divide();
    t_div_zero();
    t_restart();
    t_large();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule